// File: doc/BRIEF.md
# Cascadable Display Line Capture

This block collects one display line of 6-bit gray-level codes for a column driver. A 36-bit bus carries six 6-bit dot codes on every clock. A one-hot token walks across the stages. On each clock it selects which six-dot slot of the line data register receives the bus contents. The default is 80 stages, which gives 480 dots per line.

Several of these blocks can be chained. A direction input picks one of the two start pins as the input and makes the other the cascade output. It also sets whether the line fills from the lowest dot upward or from the highest dot downward. A chip starts filling when its selected start input is sampled high. When it writes its last slot, it raises its cascade output for one clock, so the next chip begins on the following clock. The token runs two clocks past the last slot and then stops by itself.

A rising edge on the line strobe removes the token, which ends any capture still in progress. Two inversion inputs can complement the lower half or the upper half of the bus before it is stored. The line latch, the digital-to-analog conversion and the output amplifiers are outside this block.

Top module: `lcd_line_capture`

## Requirements
- R1: A synchronous active-high reset clears the line data register to all zeros and drives both cascade outputs low.
- R2: With `dir_right` high, `strt_r_i` is the start input. A start sampled high on a clock edge stores the bus into slot 0 (`line_q[35:0]`) on that same edge. Each following edge stores the bus into the next higher slot, slot k being `line_q[36k+35:36k]`.
- R3: With `dir_right` low, `strt_l_i` is the start input and `strt_r_i` is ignored. The first group goes to the highest slot (`STAGES-1`) and filling proceeds downward. With `dir_right` high, `strt_l_i` is ignored.
- R4: Field j of the bus is `pix_bus[6j+5:6j]`, with bit 6j as its LSB. It is stored at `line_q[36s+6j+5:36s+6j]` of the slot s being written.
- R5: Counting the start edge as edge 1, the cascade output goes high after edge `STAGES` and low again after edge `STAGES+1`. The cascade output is `strt_l_o` when `dir_right` is high and `strt_r_o` when it is low. The pin not selected is held low.
- R6: Once `STAGES` groups have been stored, no further bus value is written until the next start. The register keeps its contents.
- R7: A strobe rise is `strobe` sampled high on an edge after being low on the previous edge. It removes the token: that edge and all later edges store nothing until the next start, and no cascade pulse follows. Stored data is kept.
- R8: When `inv_lo` is high, `pix_bus[17:0]` (fields 0 to 2) is stored bitwise complemented. When `inv_hi` is high, `pix_bus[35:18]` (fields 3 to 5) is stored complemented. A low control stores its half unchanged.
- R9: A start sampled while a capture is in progress restarts the fill at the first slot for the current direction. The cascade pulse is timed from the new start.
- R10: A start and a strobe rise sampled on the same edge begin a new capture: the bus is stored into the first slot on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir_right | input | 1 | 1: right start pin is input, fill upward; 0: left start pin is input, fill downward |
| strt_r_i | input | 1 | Right start pulse input |
| strt_l_i | input | 1 | Left start pulse input |
| strt_r_o | output | 1 | Right cascade start output (used when `dir_right` is 0) |
| strt_l_o | output | 1 | Left cascade start output (used when `dir_right` is 1) |
| strobe | input | 1 | Line strobe; its rising edge clears the token |
| inv_lo | input | 1 | Complement fields 0 to 2 before storage |
| inv_hi | input | 1 | Complement fields 3 to 5 before storage |
| pix_bus | input | 36 | Six 6-bit dot codes per clock |
| line_q | output | STAGES*36 | Captured line data register |

## Verification
Two pairs of events can fall on the same edge. The first pair is a start and a strobe rise. The bench makes them coincide in the middle of a capture and expects the start to win: the first slot is written on that very edge and a cascade pulse follows `STAGES-1` edges later. The second pair is a restart and an ongoing fill, which the bench provokes by pulsing the start input partway through a line. After each run the whole register is compared with a model of the slots that should have been written. The cascade outputs are also compared with the expected pulse position after every clock.

// File: rtl/lcd_line_capture.sv
module lcd_line_capture #(
  parameter int STAGES = 80,
  parameter int FIELDS = 6,
  parameter int FBITS  = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              dir_right,
  input  logic                              strt_r_i,
  input  logic                              strt_l_i,
  output logic                              strt_r_o,
  output logic                              strt_l_o,
  input  logic                              strobe,
  input  logic                              inv_lo,
  input  logic                              inv_hi,
  input  logic [FIELDS*FBITS-1:0]           pix_bus,
  output logic [STAGES*FIELDS*FBITS-1:0]    line_q
);
  localparam int GW = FIELDS * FBITS;
  localparam int HW = GW / 2;
  localparam int TW = STAGES + 2;

  logic [TW-1:0]     tok, sel;
  logic [STAGES-1:0] we;
  logic              strobe_d, casc, start_now, strobe_rise;
  logic [GW-1:0]     pix_eff;

  assign start_now   = dir_right ? strt_r_i : strt_l_i;
  assign strobe_rise = strobe & ~strobe_d;
  assign pix_eff     = pix_bus ^ {{(GW-HW){inv_hi}}, {HW{inv_lo}}};
  assign strt_l_o    = dir_right & casc;
  assign strt_r_o    = ~dir_right & casc;

  always_comb begin
    sel = '0;
    if (start_now) sel[0] = 1'b1;
    else if (!strobe_rise) sel = tok;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_we
    assign we[s] = dir_right ? sel[s] : sel[STAGES-1-s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tok      <= '0;
      casc     <= 1'b0;
      strobe_d <= 1'b0;
      line_q   <= '0;
    end else begin
      tok      <= sel << 1;
      casc     <= sel[STAGES-1];
      strobe_d <= strobe;
      for (int s = 0; s < STAGES; s++)
        if (we[s]) line_q[s*GW +: GW] <= pix_eff;
    end
  end
endmodule

module lcd_line_capture_chk #(
  parameter int STAGES = 80,
  parameter int LW     = 2880
) (
  input logic              clk,
  input logic              rst,
  input logic              dir_right,
  input logic              strt_r_i,
  input logic              strt_l_i,
  input logic              strt_r_o,
  input logic              strt_l_o,
  input logic              strobe,
  input logic              strobe_d,
  input logic [STAGES+1:0] tok,
  input logic [LW-1:0]     line_q
);
  logic st;
  assign st = dir_right ? strt_r_i : strt_l_i;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (line_q == '0 && !strt_r_o && !strt_l_o));

  assert_casc_single_R5: assert property (@(posedge clk) disable iff (rst)
    (strt_r_o || strt_l_o) |=> !(strt_r_o || strt_l_o));

  assert_casc_one_pin_R5: assert property (@(posedge clk) disable iff (rst)
    !(strt_r_o && strt_l_o));

  assert_halt_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (tok == '0 && !st) |=> $stable(line_q));

  assert_strobe_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe && !strobe_d && !st) |=> $stable(line_q));
endmodule

bind lcd_line_capture lcd_line_capture_chk #(.STAGES(STAGES), .LW(STAGES*FIELDS*FBITS)) chk_i (
  .clk(clk), .rst(rst), .dir_right(dir_right), .strt_r_i(strt_r_i), .strt_l_i(strt_l_i),
  .strt_r_o(strt_r_o), .strt_l_o(strt_l_o), .strobe(strobe), .strobe_d(strobe_d),
  .tok(tok), .line_q(line_q));

// File: tb/lcd_line_capture_tb.sv
module lcd_line_capture_tb_top;
  localparam int STAGES = 80;
  localparam int GW = 36;
  localparam int LW = STAGES * GW;

  logic clk = 0, rst = 1, dir_right = 1, strt_r_i = 0, strt_l_i = 0;
  logic strobe = 0, inv_lo = 0, inv_hi = 0;
  logic strt_r_o, strt_l_o;
  logic [GW-1:0] pix_bus = '0;
  logic [LW-1:0] line_q, exp_line;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  lcd_line_capture #(.STAGES(STAGES)) dut_i (
    .clk(clk), .rst(rst), .dir_right(dir_right), .strt_r_i(strt_r_i), .strt_l_i(strt_l_i),
    .strt_r_o(strt_r_o), .strt_l_o(strt_l_o), .strobe(strobe), .inv_lo(inv_lo),
    .inv_hi(inv_hi), .pix_bus(pix_bus), .line_q(line_q));

  function automatic logic [GW-1:0] pat(int k, int seed);
    logic [63:0] v;
    v = 64'(k + 1) * 64'h9E3779B97F4A7C15 + 64'(seed) * 64'h632BE5AB;
    return v[47:12];
  endfunction

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic run_line(input bit dr, input bit ia, input bit ib, input int seed,
                          input int restart_at, input int strobe_at, input int stray_at,
                          input int total, input string tag);
    int idx = -1;
    bit ce;
    for (int n = 1; n <= total; n++) begin
      bit st;
      st = (n == 1) || (n == restart_at);
      dir_right = dr; inv_lo = ia; inv_hi = ib;
      strt_r_i = dr ? st : (n == stray_at);
      strt_l_i = dr ? (n == stray_at) : st;
      strobe = (strobe_at > 0) && (n == strobe_at || n == strobe_at + 1);
      pix_bus = pat(n, seed);
      if (st) idx = 0;
      else if (n == strobe_at) idx = -1;
      ce = 0;
      if (idx >= 0 && idx < STAGES) begin
        int p;
        p = dr ? idx : STAGES - 1 - idx;
        exp_line[p*GW +: GW] = pix_bus ^ {{18{ib}}, {18{ia}}};
        ce = (idx == STAGES - 1);
      end
      if (idx >= 0) idx++;
      @(negedge clk);
      chk(strt_l_o == (dr & ce) && strt_r_o == (!dr & ce),
          $sformatf("R5 cascade n=%0d act r=%b l=%b exp r=%b l=%b", n, strt_r_o, strt_l_o,
                    !dr & ce, dr & ce));
    end
    strt_r_i = 0; strt_l_i = 0; strobe = 0;
    chk(line_q == exp_line, $sformatf("%s line act %h exp %h", tag, line_q, exp_line));
  endtask

  task automatic t_reset();
    chk(line_q == '0 && !strt_r_o && !strt_l_o,
        $sformatf("R1 reset line act %h exp 0, outs r=%b l=%b exp 0", line_q, strt_r_o, strt_l_o));
  endtask

  task automatic t_right_fill();
    logic [GW-1:0] g;
    run_line(1, 0, 0, 1, 0, 0, 0, STAGES + 4, "R2 R6");
    g = pat(1, 1);
    for (int j = 0; j < 6; j++)
      chk(line_q[6*j +: 6] == g[6*j +: 6],
          $sformatf("R4 field %0d act %h exp %h", j, line_q[6*j +: 6], g[6*j +: 6]));
  endtask

  task automatic t_left_fill();
    run_line(0, 1, 0, 2, 0, 0, 10, STAGES + 4, "R3 R8 lo");
    chk(line_q[LW-1 -: GW] == (pat(1, 2) ^ 36'h00003FFFF),
        $sformatf("R3 top slot act %h exp %h", line_q[LW-1 -: GW], pat(1, 2) ^ 36'h00003FFFF));
    run_line(0, 0, 1, 3, 0, 0, 0, STAGES + 4, "R8 hi");
  endtask

  task automatic t_both_inv();
    run_line(1, 1, 1, 4, 0, 0, 40, STAGES + 4, "R8 both R3 stray");
  endtask

  task automatic t_strobe_clear();
    run_line(1, 0, 0, 5, 0, 20, 0, STAGES + 4, "R7");
  endtask

  task automatic t_restart();
    run_line(1, 0, 0, 6, 30, 0, 0, 30 + STAGES + 3, "R9");
  endtask

  task automatic t_start_with_strobe();
    run_line(0, 0, 0, 7, 25, 25, 0, 25 + STAGES + 3, "R10");
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_line = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_right_fill();
    t_left_fill();
    t_both_inv();
    t_strobe_clear();
    t_restart();
    t_start_with_strobe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule